// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, how the five pipeline registers of an in-order pipeline (fetch, decode, execute, memory, write-back) advance. It looks at the opcodes now held in decode, execute and memory, the destination register of the execute instruction, the two source registers of the decode instruction and the branch outcome computed for the instruction in memory. From these it drives a hold (stall) and an insert-no-op (bubble) control for each register, and a select that lets the decode operand take the execute result directly instead of the register file copy.

All outputs are combinational functions of the present inputs. The unit is purely combinational and has no clock. A bubble is a no-op that passes through later stages without changing architectural state. The datapath that obeys these controls is outside the block.

Top module: `hazard_unit`

## Requirements
- R1: With nop (code 0) in every stage, no register IDs in use (0xF) and condition 1, every stall, bubble and bypass output is 0.
- R2: Opcodes are 4 bits: 0 nop, 1 ALU write, 2 load, 3 conditional jump (predicted taken), 4 return; other codes raise no hazard. `bypassSel` is 1 when the execute opcode is not a load and the execute destination equals decode source A.
- R3: Register ID 0xF means "no register" and never matches in any bypass or load-use comparison.
- R4: When the execute opcode is a load whose destination equals decode source A or B, fetch and decode stall (bit 0 and bit 1 of `stallVec`) and execute receives a bubble (bit 2 of `bubbleVec`).
- R5: When a return is in decode, execute or memory, fetch stalls and decode receives a bubble.
- R6: When a load-use condition and a return exist together, the load-use response wins: decode stalls and gets no bubble.
- R7: When memory holds a conditional jump with condition 0, decode and execute receive bubbles and neither fetch nor decode stalls, whatever else is present.
- R8: The memory and write-back registers (bits 3 and 4) are never stalled or bubbled.
- R9: No pipeline register is stalled and bubbled in the same cycle.
- R10: `bypassSel` is 0 while the execute opcode is a load, even when the registers match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opDec | input | 4 | Opcode held in the decode register |
| opExe | input | 4 | Opcode held in the execute register |
| opMem | input | 4 | Opcode held in the memory register |
| dstExe | input | 4 | Destination register ID of the execute instruction |
| srcDecA | input | 4 | Decode source register A |
| srcDecB | input | 4 | Decode source register B |
| condMem | input | 1 | Branch condition of the memory instruction (1 = taken) |
| stallVec | output | 5 | Hold controls, bit 0 fetch to bit 4 write-back |
| bubbleVec | output | 5 | Bubble controls, bit 0 fetch to bit 4 write-back |
| bypassSel | output | 1 | Decode operand A takes the execute result |

## Verification
The assertions assume the inputs are settled, well-defined values at the moment they are evaluated, since the block is combinational and judged only on its present inputs. They also take for granted that a return or jump code appears only in the stage the opcode input names. The stimulus changes all inputs together on the falling clock edge and draws register IDs from a narrow range that includes 0xF, so that matches, non-matches and the "no register" value all occur often. Opcodes are drawn from the defined codes plus one undefined code.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int OP_W  = 4;
  localparam int REG_W = 4;
  localparam int NUM_STAGES = 5;

  localparam logic [OP_W-1:0] OP_NOP   = 4'd0;
  localparam logic [OP_W-1:0] OP_ALU   = 4'd1;
  localparam logic [OP_W-1:0] OP_LOAD  = 4'd2;
  localparam logic [OP_W-1:0] OP_CJUMP = 4'd3;
  localparam logic [OP_W-1:0] OP_RET   = 4'd4;

  localparam logic [REG_W-1:0] REG_NONE = '1;

  localparam int ST_F = 0;
  localparam int ST_D = 1;
  localparam int ST_E = 2;
  localparam int ST_M = 3;
  localparam int ST_W = 4;

  typedef struct packed {
    logic loadUse;
    logic retBusy;
    logic mispredict;
    logic bypass;
  } haz_strobe_t;
endpackage

// File: rtl/hazard_detect.sv
module hazard_detect
  import hazard_pkg::*;
(
  input  logic [OP_W-1:0]  opDec,
  input  logic [OP_W-1:0]  opExe,
  input  logic [OP_W-1:0]  opMem,
  input  logic [REG_W-1:0] dstExe,
  input  logic [REG_W-1:0] srcDecA,
  input  logic [REG_W-1:0] srcDecB,
  input  logic             condMem,
  output haz_strobe_t      strobes
);
  logic matchA, matchB, exeIsLoad;

  always_comb begin
    matchA    = (dstExe != REG_NONE) && (dstExe == srcDecA);
    matchB    = (dstExe != REG_NONE) && (dstExe == srcDecB);
    exeIsLoad = (opExe == OP_LOAD);
    strobes.loadUse    = exeIsLoad && (matchA || matchB);
    strobes.retBusy    = (opDec == OP_RET) || (opExe == OP_RET) || (opMem == OP_RET);
    strobes.mispredict = (opMem == OP_CJUMP) && !condMem;
    strobes.bypass     = matchA && !exeIsLoad;
  end

  // R3: the none ID never produces a match
  always_comb begin
    if (srcDecA == REG_NONE && srcDecB == REG_NONE)
      p_none_nomatch_r3: assert (!strobes.loadUse && !strobes.bypass)
        else $error("none register matched");
  end
endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl
  import hazard_pkg::*;
(
  input  haz_strobe_t            strobes,
  output logic [NUM_STAGES-1:0]  stallVec,
  output logic [NUM_STAGES-1:0]  bubbleVec,
  output logic                   bypassSel
);
  always_comb begin
    stallVec  = '0;
    bubbleVec = '0;
    if (strobes.mispredict) begin
      bubbleVec[ST_D] = 1'b1;
      bubbleVec[ST_E] = 1'b1;
    end else if (strobes.loadUse) begin
      stallVec[ST_F]  = 1'b1;
      stallVec[ST_D]  = 1'b1;
      bubbleVec[ST_E] = 1'b1;
    end else if (strobes.retBusy) begin
      stallVec[ST_F]  = 1'b1;
      bubbleVec[ST_D] = 1'b1;
    end
    bypassSel = strobes.bypass;
  end

  always_comb begin
    p_no_stall_bubble_r9: assert ((stallVec & bubbleVec) == '0)
      else $error("stall and bubble together");
    p_tail_quiet_r8: assert (!stallVec[ST_M] && !stallVec[ST_W] &&
                             !bubbleVec[ST_M] && !bubbleVec[ST_W])
      else $error("memory/write-back disturbed");
    if (strobes.mispredict)
      p_squash_r7: assert (bubbleVec[ST_D] && bubbleVec[ST_E] && !stallVec[ST_F])
        else $error("mispredict not squashed");
    if (strobes.loadUse && !strobes.mispredict)
      p_load_use_r4: assert (stallVec[ST_D] && bubbleVec[ST_E] && !bubbleVec[ST_D])
        else $error("load-use response wrong");
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
(
  input  logic [3:0] opDec,
  input  logic [3:0] opExe,
  input  logic [3:0] opMem,
  input  logic [3:0] dstExe,
  input  logic [3:0] srcDecA,
  input  logic [3:0] srcDecB,
  input  logic       condMem,
  output logic [4:0] stallVec,
  output logic [4:0] bubbleVec,
  output logic       bypassSel
);
  haz_strobe_t strobes;

  hazard_detect u_detect (
    .opDec(opDec), .opExe(opExe), .opMem(opMem), .dstExe(dstExe),
    .srcDecA(srcDecA), .srcDecB(srcDecB), .condMem(condMem), .strobes(strobes)
  );

  stall_ctrl u_ctrl (
    .strobes(strobes), .stallVec(stallVec), .bubbleVec(bubbleVec), .bypassSel(bypassSel)
  );

  // R5: an outstanding return with no other hazard freezes fetch
  always_comb begin
    if ((opDec == OP_RET || opExe == OP_RET || opMem == OP_RET) && !strobes.loadUse &&
        !(opMem == OP_CJUMP && !condMem))
      p_ret_hold_r5: assert (stallVec[ST_F] && bubbleVec[ST_D])
        else $error("return did not hold fetch");
    if (opExe == OP_LOAD)
      p_no_load_bypass_r10: assert (!bypassSel)
        else $error("bypass from load");
  end
endmodule

// File: tb/tb_hazard_unit.sv
module tb_hazard_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] opDec, opExe, opMem, dstExe, srcDecA, srcDecB;
  logic       condMem;
  logic [4:0] stallVec, bubbleVec;
  logic       bypassSel;

  int tests = 0, fails = 0;

  hazard_unit dut (.*);

  function automatic void refModel(output logic [4:0] s, output logic [4:0] b, output logic byp);
    bit useHit, retSeen, squash;
    s = 0; b = 0;
    useHit = 0;
    if (opExe == 4'd2) begin
      if (dstExe != 4'hF && dstExe == srcDecA) useHit = 1;
      if (dstExe != 4'hF && dstExe == srcDecB) useHit = 1;
    end
    retSeen = (opDec == 4'd4) || (opExe == 4'd4) || (opMem == 4'd4);
    squash  = (opMem == 4'd3) && (condMem == 0);
    if (squash) b = 5'b00110;
    else if (useHit) begin s = 5'b00011; b = 5'b00100; end
    else if (retSeen) begin s = 5'b00001; b = 5'b00010; end
    byp = (opExe != 4'd2) && (dstExe != 4'hF) && (dstExe == srcDecA);
  endfunction

  task automatic check(input string tag);
    logic [4:0] es, eb; logic ebp;
    refModel(es, eb, ebp);
    tests++;
    if (stallVec !== es || bubbleVec !== eb || bypassSel !== ebp) begin
      fails++;
      $display("FAIL %s: got stall=%b bubble=%b byp=%b exp stall=%b bubble=%b byp=%b",
               tag, stallVec, bubbleVec, bypassSel, es, eb, ebp);
    end
  endtask

  task automatic apply(input logic [3:0] d, e, m, dst, sa, sb, input logic c, input string tag);
    @(negedge clk);
    opDec = d; opExe = e; opMem = m; dstExe = dst; srcDecA = sa; srcDecB = sb; condMem = c;
    @(posedge clk); #1;
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD*300000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    opDec = 0; opExe = 0; opMem = 0; dstExe = 4'hF; srcDecA = 4'hF; srcDecB = 4'hF; condMem = 1;
    apply(0, 0, 0, 4'hF, 4'hF, 4'hF, 1, "R1 idle");
    apply(1, 1, 0, 4'd3, 4'd3, 4'd5, 1, "R2 alu bypass");
    apply(1, 1, 0, 4'd3, 4'd4, 4'd3, 1, "R2 srcB no bypass");
    apply(1, 2, 0, 4'hF, 4'hF, 4'hF, 1, "R3 none load");
    apply(1, 1, 0, 4'hF, 4'hF, 4'd2, 1, "R3 none bypass");
    apply(1, 2, 0, 4'd6, 4'd6, 4'd1, 1, "R4 load-use A");
    apply(1, 2, 0, 4'd6, 4'd1, 4'd6, 1, "R4 load-use B");
    apply(4, 0, 0, 4'hF, 4'hF, 4'hF, 1, "R5 ret decode");
    apply(0, 4, 0, 4'hF, 4'hF, 4'hF, 1, "R5 ret execute");
    apply(0, 0, 4, 4'hF, 4'hF, 4'hF, 1, "R5 ret memory");
    apply(0, 2, 4, 4'd7, 4'd7, 4'hF, 1, "R6 load-use over ret");
    apply(1, 1, 3, 4'd2, 4'd9, 4'd9, 0, "R7 mispredict");
    apply(4, 2, 3, 4'd5, 4'd5, 4'd5, 0, "R7 mispredict over all");
    apply(1, 1, 3, 4'd2, 4'd2, 4'd9, 1, "R7 taken no squash");
    apply(1, 2, 0, 4'd8, 4'd8, 4'd8, 1, "R10 load no bypass");
    apply(9, 9, 9, 4'd1, 4'd1, 4'd1, 1, "R2 undefined op");
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] pick [6];
      for (int k = 0; k < 6; k++) begin
        int r = $urandom_range(0, 5);
        pick[k] = (r == 5) ? 4'd9 : 4'(r);
      end
      apply(pick[0], pick[1], pick[2],
            ($urandom_range(0, 4) == 0) ? 4'hF : 4'($urandom_range(0, 3)),
            ($urandom_range(0, 4) == 0) ? 4'hF : 4'($urandom_range(0, 3)),
            ($urandom_range(0, 4) == 0) ? 4'hF : 4'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), "R8 R9 random");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule